// File: doc/BRIEF.md
# Four-Channel Audio Divider Clock and Filter Control

This block is the shared clocking core for four divide-by-N audio channels. An 8-bit control word sets how each channel is clocked. The choices are a base tick near 64 kHz, a slower base tick near 15 kHz, or, for the first and third channels only, the full system clock. Each channel counts ticks down from its own 8-bit divisor. It emits a one-cycle pulse every divisor+1 ticks and toggles a square wave on each pulse. These pulses feed the tone stages that sit downstream.

Two pairs of channels, (1,2) and (3,4), can be chained into one 16-bit divider. The even channel holds the high byte, and the pulse appears on that channel. The two low-numbered channels can also pass through a high-pass stage. In that stage a latch samples the channel's square wave on every pulse of its partner (channel 3 or 4), and the output is the live square wave XOR the latched value. A start strobe restarts every divider and both base prescalers at the same instant. Channels 1, 2 and 4 each set an underflow flag that is held clear while its enable input is low. Control bit 7 is passed out to select the short noise polynomial.

Top module: `aud_clk_ctl`

## Requirements
- R1: After reset, chan_pulse, chan_out and irq_flag are all zero and noise_short is 0.
- R2: With control bit 0 = 0, a channel on the base tick pulses every (N+1)*28 clock cycles. With bit 0 = 1, it pulses every (N+1)*114 cycles. N is that channel's divisor.
- R3: Control bit 6 clocks channel 1, and control bit 5 clocks channel 3, on every system clock cycle, giving a period of N+1 cycles. This overrides bit 0. Channels 2 and 4 never use the system clock directly.
- R4: With control bit 4 = 1, channels 1 and 2 form one 16-bit divider clocked by channel 1's clock. It pulses on chan_pulse[1] every H*256+L+1 ticks, where H is channel 2's divisor and L is channel 1's. chan_pulse[0] stays 0.
- R5: With control bit 3 = 1, channels 3 and 4 are joined in the same way. Channel 4 is the high byte, the pulse appears on chan_pulse[3], and chan_pulse[2] stays 0.
- R6: Each channel's square wave toggles on each of its pulses, and chan_out[2], chan_out[3] give the square waves directly. When control bit 2 = 1, chan_out[0] = square1 XOR a latch, and that latch loads square1 on every pulse of channel 3. Control bit 1 does the same for channel 2 sampled by channel 4. With the enable bit 0, the output is the plain square wave.
- R7: A start_stb cycle reloads every divider from its divisor, restarts both prescalers, and clears the square waves and high-pass latches. The first pulse follows after N+1 ticks. No pulse appears in the cycle after the strobe.
- R8: Writing a divisor does not change a count in progress. The new value takes effect at that channel's next reload.
- R9: irq_flag[0], [1] and [2] belong to channels 1, 2 and 4. A flag is set in the cycle after a pulse of its channel while its irq_en bit is 1. It is forced to 0 in the cycle after irq_en is 0 and stays 0 until a later pulse.
- R10: noise_short equals bit 7 of the last control word written, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word value |
| div_we | input | 4 | Per-channel divisor write strobes |
| div_wdata | input | 8 | Divisor value |
| start_stb | input | 1 | Restart all dividers and prescalers |
| irq_en | input | 3 | Flag enables for channels 1, 2, 4 |
| chan_pulse | output | 4 | One-cycle divider pulse per channel |
| chan_out | output | 4 | Square wave per channel, filtered on 1 and 2 |
| irq_flag | output | 3 | Underflow flags for channels 1, 2, 4 |
| noise_short | output | 1 | Short noise polynomial select |

## Verification
The first-pulse latency after a start strobe is measured over a table of control words and divisors. The table covers fast and slow base ticks, the system-clock override on channels 1 and 3 with and without bit 0, and both joined pairs. Those pairs use low-only and high-only divisors, which separates byte order and the +1 term. Equal-rate sampling on the high-pass path is compared against the unfiltered square wave, and the two give very different high counts. A divisor rewrite in mid-count shows whether the count in progress is kept. Flag enable and clear sequences show set, clear and masking per channel.

// File: rtl/aud_clk_pkg.sv
`timescale 1ns/1ps
package aud_clk_pkg;
    localparam int NUM_CH  = 4;
    localparam int NUM_IRQ = 3;
    localparam int CTL_W   = 8;

    // Control word bit positions (decoded by the channel logic)
    localparam int CB_SLOWBASE = 0;
    localparam int CB_HP2      = 1;
    localparam int CB_HP1      = 2;
    localparam int CB_JOIN34   = 3;
    localparam int CB_JOIN12   = 4;
    localparam int CB_FAST3    = 5;
    localparam int CB_FAST1    = 6;
    localparam int CB_NOISE9   = 7;
endpackage

// File: rtl/aud_tick_gen.sv
`timescale 1ns/1ps
module aud_tick_gen #(
    parameter int DIV = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick = !clr && (st_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/aud_div_pair.sv
`timescale 1ns/1ps
module aud_div_pair #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          join_en,
    input  logic          lo_tick,
    input  logic          hi_tick,
    input  logic [DW-1:0] div_lo,
    input  logic [DW-1:0] div_hi,
    output logic          lo_pulse,
    output logic          hi_pulse,
    output logic          lo_sq,
    output logic          hi_sq
);
    localparam int WW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] cnt_lo;
        logic [DW-1:0] cnt_hi;
        logic          p_lo;
        logic          p_hi;
        logic          sq_lo;
        logic          sq_hi;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic [WW-1:0] wide_q;

    always_comb begin
        st_d   = st_q;
        wide_q = {st_q.cnt_hi, st_q.cnt_lo};
        st_d.p_lo = 1'b0;
        st_d.p_hi = 1'b0;
        if (reload) begin
            st_d.cnt_lo = div_lo;
            st_d.cnt_hi = div_hi;
            st_d.sq_lo  = 1'b0;
            st_d.sq_hi  = 1'b0;
        end else begin
            if (join_en) begin
                // chained: low byte borrow runs into the high byte
                if (lo_tick) begin
                    if (wide_q == '0) begin
                        {st_d.cnt_hi, st_d.cnt_lo} = {div_hi, div_lo};
                        st_d.p_hi = 1'b1;
                    end else begin
                        {st_d.cnt_hi, st_d.cnt_lo} = wide_q - WW'(1);
                    end
                end
            end else begin
                if (lo_tick) begin
                    if (st_q.cnt_lo == '0) begin
                        st_d.cnt_lo = div_lo;
                        st_d.p_lo   = 1'b1;
                    end else begin
                        st_d.cnt_lo = st_q.cnt_lo - 1'b1;
                    end
                end
                if (hi_tick) begin
                    if (st_q.cnt_hi == '0) begin
                        st_d.cnt_hi = div_hi;
                        st_d.p_hi   = 1'b1;
                    end else begin
                        st_d.cnt_hi = st_q.cnt_hi - 1'b1;
                    end
                end
            end
            st_d.sq_lo = st_q.sq_lo ^ st_d.p_lo;
            st_d.sq_hi = st_q.sq_hi ^ st_d.p_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_pulse = st_q.p_lo;
    assign hi_pulse = st_q.p_hi;
    assign lo_sq    = st_q.sq_lo;
    assign hi_sq    = st_q.sq_hi;
endmodule

// File: rtl/aud_hp_stage.sv
`timescale 1ns/1ps
module aud_hp_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sq,
    input  logic sample,
    output logic out
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (clr || !en) begin
            hold_d = 1'b0;
        end else if (sample) begin
            hold_d = sq;
        end
        out = en ? (sq ^ hold_q) : sq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/aud_clk_ctl.sv
`timescale 1ns/1ps
module aud_clk_ctl
    import aud_clk_pkg::*;
#(
    parameter int DW       = 8,
    parameter int FAST_DIV = 28,
    parameter int SLOW_DIV = 114
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [NUM_CH-1:0] div_we,
    input  logic [DW-1:0]     div_wdata,
    input  logic              start_stb,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic [NUM_CH-1:0] chan_pulse,
    output logic [NUM_CH-1:0] chan_out,
    output logic [NUM_IRQ-1:0] irq_flag,
    output logic              noise_short
);
    localparam int NUM_PAIR = NUM_CH / 2;

    typedef struct packed {
        logic [CTL_W-1:0]            ctl;
        logic [NUM_CH-1:0][DW-1:0]   div;
        logic [NUM_IRQ-1:0]          flag;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CTL_W-1:0]  ctl_cur;
    logic              fast_tick, slow_tick, base_tick;
    logic [NUM_CH-1:0] pulse, sq;
    logic [NUM_PAIR-1:0] hp_out;
    logic [NUM_IRQ-1:0]  irq_src;

    assign ctl_cur = st_q.ctl;

    aud_tick_gen #(.DIV(FAST_DIV)) u_fast_tick (
        .clk(clk), .rst_n(rst_n), .clr(start_stb), .tick(fast_tick)
    );
    aud_tick_gen #(.DIV(SLOW_DIV)) u_slow_tick (
        .clk(clk), .rst_n(rst_n), .clr(start_stb), .tick(slow_tick)
    );

    assign base_tick = ctl_cur[CB_SLOWBASE] ? slow_tick : fast_tick;

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        localparam int FB = (p == 0) ? CB_FAST1  : CB_FAST3;
        localparam int JB = (p == 0) ? CB_JOIN12 : CB_JOIN34;
        localparam int HB = (p == 0) ? CB_HP1    : CB_HP2;
        logic lo_tick;
        assign lo_tick = ctl_cur[FB] ? 1'b1 : base_tick;

        aud_div_pair #(.DW(DW)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload   (start_stb),
            .join_en  (ctl_cur[JB]),
            .lo_tick  (lo_tick),
            .hi_tick  (base_tick),
            .div_lo   (st_q.div[2*p]),
            .div_hi   (st_q.div[2*p+1]),
            .lo_pulse (pulse[2*p]),
            .hi_pulse (pulse[2*p+1]),
            .lo_sq    (sq[2*p]),
            .hi_sq    (sq[2*p+1])
        );

        // channel p filtered, sampled by channel p+2
        aud_hp_stage u_hp (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (start_stb),
            .en     (ctl_cur[HB]),
            .sq     (sq[p]),
            .sample (pulse[p+2]),
            .out    (hp_out[p])
        );
    end

    assign irq_src = {pulse[3], pulse[1], pulse[0]};

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_wdata;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (div_we[i]) begin
                st_d.div[i] = div_wdata;
            end
        end
        for (int k = 0; k < NUM_IRQ; k++) begin
            st_d.flag[k] = irq_en[k] ? (st_q.flag[k] | irq_src[k]) : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_pulse  = pulse;
    assign chan_out    = {sq[3], sq[2], hp_out[1], hp_out[0]};
    assign irq_flag    = st_q.flag;
    assign noise_short = ctl_cur[CB_NOISE9];
endmodule

// File: rtl/aud_clk_ctl_chk.sv
`timescale 1ns/1ps
module aud_clk_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_stb,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic [2:0] irq_en,
    input logic [7:0] ctl_cur,
    input logic [3:0] chan_pulse,
    input logic [3:0] chan_out,
    input logic [2:0] irq_flag,
    input logic       noise_short
);
    // R4
    join12_lo_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_cur[4]) |-> !chan_pulse[0]);

    // R5
    join34_lo_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_cur[3]) |-> !chan_pulse[2]);

    // R7
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_stb) |-> (chan_pulse == 4'b0 && chan_out == 4'b0));

    // R9
    flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag & ~$past(irq_en)) == 3'b0);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_en[0] && chan_pulse[0]) |-> irq_flag[0]);

    // R10
    noise_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we) |-> (noise_short == $past(ctl_wdata[7])));
endmodule

bind aud_clk_ctl aud_clk_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_stb   (start_stb),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .irq_en      (irq_en),
    .ctl_cur     (ctl_cur),
    .chan_pulse  (chan_pulse),
    .chan_out    (chan_out),
    .irq_flag    (irq_flag),
    .noise_short (noise_short)
);

// File: tb/tb_aud_clk_ctl.sv
`timescale 1ns/1ps
module tb_aud_clk_ctl;
    localparam int CLK_P = 10;
    localparam int NVEC  = 9;

    typedef struct packed {
        logic [7:0]  ctl;
        logic [31:0] divs;   // {div4, div3, div2, div1}
        logic [1:0]  ch;
        logic [15:0] lat;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 32'h0000_0002, 2'd0, 16'd84,  4'd2},  // R2 fast base
        '{8'h01, 32'h0000_0100, 2'd1, 16'd228, 4'd2},  // R2 slow base
        '{8'h40, 32'h0000_0005, 2'd0, 16'd6,   4'd3},  // R3 ch1 sysclk
        '{8'h41, 32'h0000_0007, 2'd0, 16'd8,   4'd3},  // R3 override slow
        '{8'h20, 32'h0000_0000, 2'd2, 16'd1,   4'd3},  // R3 ch3 sysclk
        '{8'h21, 32'h0000_0000, 2'd3, 16'd114, 4'd3},  // R3 ch4 stays on base
        '{8'h50, 32'h0000_0102, 2'd1, 16'd259, 4'd4},  // R4 joined 1+2
        '{8'h28, 32'h0004_0000, 2'd3, 16'd5,   4'd5},  // R5 low byte only
        '{8'h28, 32'h0200_0000, 2'd3, 16'd513, 4'd5}   // R5 high byte only
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [3:0] div_we = 4'h0;
    logic [7:0] div_wdata = 8'h00;
    logic       start_stb = 1'b0;
    logic [2:0] irq_en = 3'b000;
    logic [3:0] chan_pulse, chan_out;
    logic [2:0] irq_flag;
    logic       noise_short;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aud_clk_ctl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .start_stb(start_stb),
        .irq_en(irq_en), .chan_pulse(chan_pulse), .chan_out(chan_out),
        .irq_flag(irq_flag), .noise_short(noise_short)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_div(input int ch, input logic [7:0] v);
        @(negedge clk); div_we = 4'h0; div_we[ch] = 1'b1; div_wdata = v;
        @(negedge clk); div_we = 4'h0;
    endtask

    task automatic do_start(output int s);
        @(negedge clk); start_stb = 1'b1; s = cyc + 1;
        @(negedge clk); start_stb = 1'b0;
    endtask

    task automatic wait_pulse(input int ch, input int lim, output int at);
        at = -1;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); @(negedge clk);
            if (chan_pulse[ch]) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s, at, at2, mism, hi, cnt0, cnt1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 chan_pulse", int'(chan_pulse), 0);
        check("R1 chan_out", int'(chan_out), 0);
        check("R1 irq_flag", int'(irq_flag), 0);
        check("R1 noise_short", int'(noise_short), 0);

        // table of first-pulse latencies (R2 R3 R4 R5 R7)
        for (int v = 0; v < NVEC; v++) begin
            wr_ctl(VECS[v].ctl);
            for (int c = 0; c < 4; c++) wr_div(c, VECS[v].divs[8*c +: 8]);
            do_start(s);
            wait_pulse(int'(VECS[v].ch), 1000, at);
            check($sformatf("R%0d vec%0d latency (R7 restart)", VECS[v].req, v),
                  (at < 0) ? -1 : at - s, int'(VECS[v].lat));
        end

        // R4 joined pair: low channel silent, high pulses every cycle
        wr_ctl(8'h50); wr_div(0, 8'h00); wr_div(1, 8'h00);
        do_start(s);
        cnt0 = 0; cnt1 = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            cnt0 += int'(chan_pulse[0]); cnt1 += int'(chan_pulse[1]);
        end
        check("R4 ch1 pulses while joined", cnt0, 0);
        check("R4 ch2 pulses divisor 0", cnt1, 20);

        // R6 high-pass with equal-rate sampler: output equals pulse train
        wr_ctl(8'h64); wr_div(0, 8'd4); wr_div(2, 8'd4);
        do_start(s);
        mism = 0; hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); @(negedge clk);
            mism += int'(chan_out[0] != chan_pulse[0]);
            hi += int'(chan_out[0]);
        end
        check("R6 hp out vs pulse mismatches", mism, 0);
        check("R6 hp out high cycles", hi, 12);
        // R6 filter off: plain square wave
        wr_ctl(8'h60);
        do_start(s);
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); @(negedge clk);
            hi += int'(chan_out[0]);
        end
        check("R6 square high cycles", hi, 30);

        // R8 divisor rewrite during count
        wr_ctl(8'h40); wr_div(0, 8'd9);
        do_start(s);
        repeat (3) @(negedge clk);
        wr_div(0, 8'd2);
        wait_pulse(0, 100, at);
        check("R8 count kept old divisor", at - s, 10);
        wait_pulse(0, 100, at2);
        check("R8 new divisor after reload", at2 - at, 3);

        // R9 flag set, clear, re-enable
        wr_ctl(8'h40); wr_div(0, 8'd3);
        irq_en = 3'b001;
        do_start(s);
        wait_pulse(0, 100, at);
        @(posedge clk); @(negedge clk);
        check("R9 flag0 set", int'(irq_flag[0]), 1);
        irq_en = 3'b000;
        @(posedge clk); @(negedge clk);
        check("R9 flag0 cleared", int'(irq_flag[0]), 0);
        irq_en = 3'b001;
        @(posedge clk); @(negedge clk);
        check("R9 flag0 stays clear", int'(irq_flag[0]), 0);
        // R9 channel 4 flag, channel 2 masked
        wr_ctl(8'h00); wr_div(1, 8'd0); wr_div(3, 8'd0);
        irq_en = 3'b100;
        do_start(s);
        wait_pulse(3, 200, at);
        @(posedge clk); @(negedge clk);
        check("R9 flag2 from ch4", int'(irq_flag[2]), 1);
        check("R9 flag1 masked", int'(irq_flag[1]), 0);
        irq_en = 3'b000;

        // R10 noise select
        wr_ctl(8'h80);
        check("R10 noise_short set", int'(noise_short), 1);
        wr_ctl(8'h7F);
        check("R10 noise_short clear", int'(noise_short), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule